// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. Software sets a start request and chooses a 3-bit acquisition code. The sequencer can then hold off for an automatic acquisition interval. After that it runs a bit-by-bit search, paced by a single-cycle conversion tick. The tick comes from a programmable divider of the system clock.

During the search the block drives a sample/hold line and a trial code to an external DAC and comparator. It reads back one comparator decision for each bit. On completion it loads the result register, drops busy and raises an interrupt flag. Software can abort a conversion by clearing the busy/start request, and the stored result is then left as it was. Every completion and every abort is followed by a fixed two-tick recovery interval. A start request that arrives during recovery is held and launched when recovery ends.

All control and status pins are plain levels or single-cycle pulses. The result leaves as a register value, so no handshake or back-pressure applies at the edges of this block.

Top module: `sar_seq`

## Requirements
- R1: After reset the state is idle with busy=0, sh_hold=0, irq_flag=0, result=0 and trial_code=0.
- R2: With acq_code=000, sh_hold goes high in the first cycle after the cycle in which start_set is sampled.
- R3: acq_code values 000 to 111 give 0, 2, 4, 6, 8, 12, 16 and 20 conversion ticks of automatic acquisition before sh_hold goes high.
- R4: sh_hold stays high for exactly 11 conversion-tick periods. trial_code is zero whenever sh_hold is low and during the first conversion period.
- R5: Bits are searched from bit 9 down to bit 0. Each trial code is the bits already decided with the current bit set (the first trial is 10'h200). The current bit is kept when cmp_ge=1, meaning the input is at or above the DAC output.
- R6: In the cycle after the last bit, result holds the searched code, busy is 0, irq_flag is 1 and sh_hold is 0.
- R7: If start_clr is asserted during acquisition or conversion, the block aborts: busy drops and sh_hold drops, result keeps its old value, and irq_flag is not set.
- R8: Every completion or abort is followed by a recovery of 2 conversion ticks. A start_set seen during recovery raises busy at once and launches the conversion when recovery ends.
- R9: irq_flag stays set until irq_clr=1 clears it. If a completion and irq_clr fall in the same cycle, the flag is set.
- R10: res_wr_en=1 loads res_wr_data into result. If a completion falls in the same cycle, the conversion result wins.
- R11: A conversion tick occurs every cfg_div+1 system clock cycles. With cfg_div=0 there is a tick on every cycle.
- R12: start_set is ignored while acquisition or conversion is active. When start_set and start_clr are asserted in the same cycle, start_clr wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Tick divider: a tick every cfg_div+1 cycles |
| acq_code | input | 3 | Automatic acquisition length code |
| start_set | input | 1 | Software start request (one-cycle pulse) |
| start_clr | input | 1 | Software clear of busy; aborts or cancels the request |
| res_wr_en | input | 1 | Software write strobe for the result register |
| res_wr_data | input | RES_W | Software write data for the result register |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| cmp_ge | input | 1 | Comparator decision: input >= DAC output |
| sh_hold | output | 1 | 1 = hold capacitor disconnected (conversion running) |
| trial_code | output | RES_W | Code presented to the DAC |
| busy | output | 1 | Start/busy status bit |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| result | output | RES_W | Result register |

## Verification
The bench builds the block with the default parameters: RES_W=10 and DIV_W=4. It runs most scenarios with cfg_div=0, where one tick falls on every cycle. This makes the acquisition lengths, the 11-period conversion and the 2-tick recovery exact cycle counts, and makes abort and pending-start timing checkable to the cycle. A run with cfg_div=2 brings divided pacing within reach: the first conversion period is partial, so the hold interval falls in a bounded window.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int ACQ_W = 5;
  localparam int RECOV_TICKS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_CONV  = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_t;

  function automatic logic [ACQ_W-1:0] acq_ticks(input logic [2:0] code);
    case (code)
      3'd0:    acq_ticks = ACQ_W'(0);
      3'd1:    acq_ticks = ACQ_W'(2);
      3'd2:    acq_ticks = ACQ_W'(4);
      3'd3:    acq_ticks = ACQ_W'(6);
      3'd4:    acq_ticks = ACQ_W'(8);
      3'd5:    acq_ticks = ACQ_W'(12);
      3'd6:    acq_ticks = ACQ_W'(16);
      default: acq_ticks = ACQ_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_span_timer.sv
module sar_span_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = tick && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] final_code,
  output logic             last
);
  localparam int PW = $clog2(RES_W + 1);

  logic [PW-1:0]    ptr;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] cur_mask;

  // period 0 settles the hold; period k resolves bit RES_W-k
  for (genvar i = 0; i < RES_W; i++) begin : g_mask
    assign cur_mask[i] = (ptr != '0) && (int'(ptr) == RES_W - i);
  end

  assign trial      = decided | cur_mask;
  assign final_code = cmp_ge ? (decided | cur_mask) : decided;
  assign last       = (ptr == PW'(RES_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      decided <= '0;
    end else if (clear) begin
      ptr     <= '0;
      decided <= '0;
    end else if (step) begin
      if (!last) ptr <= ptr + 1'b1;
      if (cmp_ge) decided <= decided | cur_mask;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W = 10,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [2:0]       acq_code,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic             res_wr_en,
  input  logic [RES_W-1:0] res_wr_data,
  input  logic             irq_clr,
  input  logic             cmp_ge,
  output logic             sh_hold,
  output logic [RES_W-1:0] trial_code,
  output logic             busy,
  output logic             irq_flag,
  output logic [RES_W-1:0] result
);
  import sar_pkg::*;

  seq_state_t       state, st_n;
  logic             busy_n, pend, pend_n;
  logic             tick, expire, last;
  logic             load, conv_enter, done, launch, start_req;
  logic [ACQ_W-1:0] load_val, acq_len;
  logic [RES_W-1:0] trial_raw, final_code;

  sar_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  sar_span_timer #(.W(ACQ_W)) u_span (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .tick(tick), .expire(expire)
  );

  sar_approx_reg #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clear(conv_enter),
    .step(tick && state == ST_CONV), .cmp_ge(cmp_ge),
    .trial(trial_raw), .final_code(final_code), .last(last)
  );

  assign start_req = start_set && !start_clr;
  assign acq_len   = acq_ticks(acq_code);
  assign sh_hold   = (state == ST_CONV);
  assign trial_code = sh_hold ? trial_raw : '0;

  always_comb begin
    st_n       = state;
    busy_n     = busy;
    pend_n     = pend;
    load       = 1'b0;
    load_val   = '0;
    conv_enter = 1'b0;
    done       = 1'b0;
    launch     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_req) launch = 1'b1;
      end
      ST_ACQ: begin
        if (start_clr) begin
          st_n = ST_RECOV; busy_n = 1'b0;
          load = 1'b1; load_val = ACQ_W'(RECOV_TICKS);
        end else if (expire) begin
          st_n = ST_CONV; conv_enter = 1'b1;
        end
      end
      ST_CONV: begin
        if (start_clr) begin
          st_n = ST_RECOV; busy_n = 1'b0;
          load = 1'b1; load_val = ACQ_W'(RECOV_TICKS);
        end else if (tick && last) begin
          st_n = ST_RECOV; busy_n = 1'b0; done = 1'b1;
          load = 1'b1; load_val = ACQ_W'(RECOV_TICKS);
        end
      end
      default: begin
        pend_n = (pend || start_set) && !start_clr;
        if (start_clr)      busy_n = 1'b0;
        else if (start_set) busy_n = 1'b1;
        if (expire) begin
          pend_n = 1'b0;
          if ((pend || start_set) && !start_clr) launch = 1'b1;
          else                                  st_n = ST_IDLE;
        end
      end
    endcase
    if (launch) begin
      busy_n = 1'b1;
      if (acq_len == '0) begin
        st_n = ST_CONV; conv_enter = 1'b1;
      end else begin
        st_n = ST_ACQ; load = 1'b1; load_val = acq_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      pend     <= 1'b0;
      irq_flag <= 1'b0;
      result   <= '0;
    end else begin
      state <= st_n;
      busy  <= busy_n;
      pend  <= pend_n;
      if (done)         irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
      if (done)           result <= final_code;
      else if (res_wr_en) result <= res_wr_data;
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_wr_en,
  input logic             irq_clr,
  input logic             sh_hold,
  input logic             busy,
  input logic             irq_flag,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] trial_code
);
  // R4: no trial code outside the hold interval
  assert_trial_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_hold |-> trial_code == '0);

  // R6 / R7: leaving the hold interval always drops busy
  assert_hold_end_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_hold) |-> !busy);

  // R6: interrupt rises only as a conversion ends
  assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(sh_hold) && !sh_hold));

  // R9: flag holds until cleared
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R7 / R10: result moves only on software write or conversion end
  assert_result_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($past(res_wr_en) || $past(sh_hold)));

  // R4: hold only while busy
  assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sh_hold |-> busy);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_wr_en(res_wr_en), .irq_clr(irq_clr),
  .sh_hold(sh_hold), .busy(busy), .irq_flag(irq_flag),
  .result(result), .trial_code(trial_code)
);

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int RES_W = 10;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [2:0]       acq_code = '0;
  logic             start_set = 1'b0, start_clr = 1'b0;
  logic             res_wr_en = 1'b0, irq_clr = 1'b0;
  logic [RES_W-1:0] res_wr_data = '0;
  logic [RES_W-1:0] vin = '0;
  logic             cmp_ge;
  logic             sh_hold, busy, irq_flag;
  logic [RES_W-1:0] trial_code, result;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp_ge = (vin >= trial_code);

  sar_seq #(.RES_W(RES_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .acq_code(acq_code),
    .start_set(start_set), .start_clr(start_clr), .res_wr_en(res_wr_en),
    .res_wr_data(res_wr_data), .irq_clr(irq_clr), .cmp_ge(cmp_ge),
    .sh_hold(sh_hold), .trial_code(trial_code), .busy(busy),
    .irq_flag(irq_flag), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measures wait before hold and length of hold; checks first trials
  task automatic run_conv(input logic [2:0] code, input int v,
                          output int w, output int h);
    acq_code = code;
    vin = RES_W'(v);
    pulse_start();
    w = 1;
    while (!sh_hold && w < 200) begin @(negedge clk); w++; end
    h = 0;
    while (sh_hold && h < 200) begin
      if (cfg_div == 0 && h == 0) chk(trial_code == 0, "R4 first period trial", trial_code, 0);
      if (cfg_div == 0 && h == 1) chk(trial_code == 10'h200, "R5 msb trial", trial_code, 10'h200);
      @(negedge clk); h++;
    end
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(sh_hold == 0, "R1 sh_hold", sh_hold, 0);
    chk(irq_flag == 0, "R1 irq", irq_flag, 0);
    chk(result == 0, "R1 result", result, 0);
    chk(trial_code == 0, "R1 trial", trial_code, 0);
  endtask

  task automatic t_code(input logic [2:0] code, input int ticks, input int v);
    int w, h;
    cfg_div = 0;
    run_conv(code, v, w, h);
    chk(w == ticks + 1, code == 0 ? "R2 start latency" : "R3 acquisition ticks", w, ticks + 1);
    chk(h == 11, "R4 hold periods", h, 11);
    chk(result == v, "R5 R6 result", result, v);
    chk(busy == 0, "R6 busy", busy, 0);
    chk(irq_flag == 1, "R6 irq", irq_flag, 1);
    idle_wait(4);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq_flag == 0, "R9 clear", irq_flag, 0);
  endtask

  task automatic t_divided();
    int w, h;
    cfg_div = 2;
    run_conv(3'd0, 613, w, h);
    chk(h >= 31 && h <= 33, "R11 divided hold", h, 32);
    chk(result == 613, "R11 divided result", result, 613);
    idle_wait(12);
    cfg_div = 0;
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic t_abort_pending();
    logic [RES_W-1:0] prev;
    int h;
    prev = result;
    cfg_div = 0;
    acq_code = 3'd0;
    vin = 10'h3F0;
    pulse_start();
    idle_wait(3);
    start_clr = 1'b1;
    @(negedge clk);
    start_clr = 1'b0;
    chk(sh_hold == 0, "R7 abort hold", sh_hold, 0);
    chk(busy == 0, "R7 abort busy", busy, 0);
    chk(result == prev, "R7 result kept", result, prev);
    chk(irq_flag == 0, "R7 no irq", irq_flag, 0);
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    chk(busy == 1, "R8 pending busy", busy, 1);
    chk(sh_hold == 0, "R8 recovery wait", sh_hold, 0);
    @(negedge clk);
    chk(sh_hold == 1, "R8 pending launch", sh_hold, 1);
    h = 0;
    while (sh_hold && h < 200) begin @(negedge clk); h++; end
    chk(result == 10'h3F0, "R8 pending result", result, 10'h3F0);
    idle_wait(4);
  endtask

  task automatic t_ignore_start();
    int h;
    cfg_div = 0;
    acq_code = 3'd0;
    vin = 10'd77;
    pulse_start();
    idle_wait(4);
    pulse_start();
    irq_clr = 1'b1;
    h = 0;
    while (sh_hold && h < 200) begin @(negedge clk); h++; end
    chk(irq_flag == 1, "R9 set beats clear", irq_flag, 1);
    irq_clr = 1'b0;
    chk(result == 77, "R12 result", result, 77);
    for (int i = 0; i < 6; i++) begin
      chk(sh_hold == 0 && busy == 0, "R12 ignored start", {busy, sh_hold}, 0);
      @(negedge clk);
    end
    start_set = 1'b1; start_clr = 1'b1;
    @(negedge clk);
    start_set = 1'b0; start_clr = 1'b0;
    @(negedge clk);
    chk(busy == 0 && sh_hold == 0, "R12 clear wins", {busy, sh_hold}, 0);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic t_write();
    @(negedge clk); res_wr_en = 1'b1; res_wr_data = 10'h123;
    @(negedge clk); res_wr_en = 1'b0;
    chk(result == 10'h123, "R10 software write", result, 10'h123);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_code(3'd0, 0, 0);
    t_code(3'd0, 0, 1023);
    t_code(3'd2, 4, 10'h2AA);
    t_code(3'd1, 2, 10'h155);
    t_code(3'd7, 20, 513);
    t_code(3'd5, 12, 1);
    t_divided();
    t_write();
    t_abort_pending();
    t_ignore_start();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule